// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block sequences one programmed-I/O access on an IDE channel. It has a small bank of packed timing registers. Each access request carries a drive number, a read/write flag and a command-block flag. The block looks up the address-setup, active-strobe and recovery lengths for the addressed drive. It then drives the address-valid qualifier, and drives either the read strobe or the write strobe during the active phase. A one-clock completion pulse marks the final recovery clock.

The timing values are stored in a compact, non-linear form. The setup length is a 2-bit code held in the top two bits of a setup register. The remaining six bits of that register are kept, but they do not affect timing. The active and recovery lengths are two nibbles of a strobe register, and a nibble of zero stands for sixteen clocks. The recovery phase lasts one extra clock when the silicon revision input is above one. Drives 0 and 1 each own a register pair, while drives 2 and 3 share a single pair. Command-block accesses ignore the registers and always run at the slowest timing.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, ready is high and addr_valid, rd_strobe, wr_strobe and done are low. Every register reads back 0x00, so every drive runs 4 setup, 16 active and 16 recovery clocks (plus the revision adjustment).
- R2: Bits 7:6 of a setup register select the setup phase length: 00 gives 4 clocks, 01 gives 2 clocks, 10 gives 3 clocks and 11 gives 5 clocks.
- R3: Bits 5:0 of a setup register are stored and read back unchanged on cfg_rdata, and they have no effect on any phase length.
- R4: In a strobe register, bits 7:4 give the active length and bits 3:0 give the recovery length. The value 0 means 16 clocks and any other value n means n clocks.
- R5: The active phase is never shorter than 2 clocks, so a nibble of 1 gives 2 clocks.
- R6: When chip_rev is greater than 1, the recovery phase lasts the decoded count plus one clock. Otherwise it lasts exactly the decoded count.
- R7: The register addresses are: 0 for the drive 0 setup register, 1 for the drive 0 strobe register, 2 and 3 for drive 1, and 4 and 5 for the pair shared by drives 2 and 3. A write to address 6 or 7 is ignored, and those addresses read back 0. Writing one drive's pair never changes another drive's timing.
- R8: An access with req_cmd high uses 4 setup, 16 active and 16 recovery clocks (plus the revision adjustment), whatever the registers hold.
- R9: Each access runs setup, then active, then recovery. addr_valid is high in all three phases. Only in the active phase is rd_strobe high (req_write=0) or wr_strobe high (req_write=1), and the two strobes are never high together.
- R10: A request is taken only while ready is high. ready stays low from the clock after acceptance through the last recovery clock. done is high for exactly that last recovery clock, and ready is high again on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_rev | input | 2 | Silicon revision; above 1 lengthens recovery by one clock |
| cfg_we | input | 1 | Timing register write enable |
| cfg_addr | input | 3 | Timing register address |
| cfg_wdata | input | 8 | Timing register write data |
| cfg_rdata | output | 8 | Timing register read data for cfg_addr |
| req | input | 1 | Access request |
| req_drive | input | 2 | Drive number 0 to 3 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_cmd | input | 1 | Command-block access, slowest timing |
| ready | output | 1 | High while idle and able to accept a request |
| addr_valid | output | 1 | Address qualifier, high for the whole access |
| rd_strobe | output | 1 | Read strobe, active phase only |
| wr_strobe | output | 1 | Write strobe, active phase only |
| done | output | 1 | One-clock pulse on the last recovery clock |

## Verification
A request presented before a clock edge is taken at that edge. addr_valid rises in the following cycle and the setup phase starts there. The active phase follows setup at once, and recovery follows active at once. done falls in the last recovery cycle and ready returns one cycle later. The bench drives requests and samples outputs on falling edges. It measures each phase by counting sampled cycles, and it checks done's position against the total length of the access. Register writes take effect at the next rising edge, so every access is issued only after its configuration write has settled.

// File: rtl/pio_timing_pkg.sv
// Package: shared constants, phase type and count decoders for the PIO
// strobe timing generator. Assumes 8-bit timing registers.
package pio_timing_pkg;

    localparam int LEN_W = 5;   // holds lengths up to 17 clocks

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_REC   = 2'd3
    } phase_t;

    // Decode the 2-bit setup code into a clock count.
    function automatic logic [LEN_W-1:0] setup_len(input logic [1:0] code);
        case (code)
            2'b00:   setup_len = LEN_W'(4);
            2'b01:   setup_len = LEN_W'(2);
            2'b10:   setup_len = LEN_W'(3);
            default: setup_len = LEN_W'(5);
        endcase
    endfunction

    // Decode a nibble where zero stands for sixteen.
    function automatic logic [LEN_W-1:0] nib_len(input logic [3:0] nib);
        nib_len = (nib == 4'd0) ? LEN_W'(16) : LEN_W'(nib);
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
// Module: timing register bank. Holds one setup/strobe register pair per
// register set; set N occupies addresses 2N (setup) and 2N+1 (strobe).
// Assumes synchronous active-low reset; unmapped addresses read zero.
module pio_timing_regs #(
    parameter int SETS   = 3,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output logic [SETS-1:0][REG_W-1:0]  setup_regs,
    output logic [SETS-1:0][REG_W-1:0]  strobe_regs
);
    localparam int SET_W = ADDR_W - 1;

    logic [SET_W-1:0] addr_set;
    logic             addr_is_strobe;

    assign addr_set       = addr[ADDR_W-1:1];
    assign addr_is_strobe = addr[0];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        // Update one register pair on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                setup_regs[g]  <= '0;
                strobe_regs[g] <= '0;
            end else if (we && (addr_set == SET_W'(g))) begin
                if (addr_is_strobe) strobe_regs[g] <= wdata;
                else                setup_regs[g]  <= wdata;
            end
        end
    end

    // Return the addressed register, or zero when unmapped.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < SETS; i++) begin
            if (addr_set == SET_W'(i))
                rdata = addr_is_strobe ? strobe_regs[i] : setup_regs[i];
        end
    end

endmodule

// File: rtl/pio_len_decode.sv
// Module: maps a drive number to its register set and decodes the three
// phase lengths. Drives at or above SETS-1 share the last set. Command
// accesses take the slowest timing. Revision above 1 adds a recovery clock.
module pio_len_decode
    import pio_timing_pkg::*;
#(
    parameter int SETS    = 3,
    parameter int REG_W   = 8,
    parameter int DRIVE_W = 2
) (
    input  logic [SETS-1:0][REG_W-1:0] setup_regs,
    input  logic [SETS-1:0][REG_W-1:0] strobe_regs,
    input  logic [DRIVE_W-1:0]         drive,
    input  logic                       cmd,
    input  logic [1:0]                 chip_rev,
    output logic [LEN_W-1:0]           s_len,
    output logic [LEN_W-1:0]           a_len,
    output logic [LEN_W-1:0]           r_len
);
    localparam int LAST = SETS - 1;

    logic [REG_W-1:0] sel_setup;
    logic [REG_W-1:0] sel_strobe;
    logic [LEN_W-1:0] a_raw;
    logic [LEN_W-1:0] r_raw;

    // Pick the register pair for the requested drive.
    always_comb begin
        sel_setup  = setup_regs[LAST];
        sel_strobe = strobe_regs[LAST];
        for (int i = 0; i < LAST; i++) begin
            if (drive == DRIVE_W'(i)) begin
                sel_setup  = setup_regs[i];
                sel_strobe = strobe_regs[i];
            end
        end
    end

    // Decode fields, apply minimum active and revision adjustment.
    always_comb begin
        if (cmd) begin
            s_len = setup_len(2'b00);
            a_raw = nib_len(4'd0);
            r_raw = nib_len(4'd0);
        end else begin
            s_len = setup_len(sel_setup[REG_W-1 -: 2]);
            a_raw = nib_len(sel_strobe[7:4]);
            r_raw = nib_len(sel_strobe[3:0]);
        end
        a_len = (a_raw < LEN_W'(2)) ? LEN_W'(2) : a_raw;
        r_len = (chip_rev > 2'd1) ? r_raw + LEN_W'(1) : r_raw;
    end

endmodule

// File: rtl/pio_phase_fsm.sv
// Module: access sequencer. Latches the decoded lengths on acceptance and
// steps through setup, active and recovery, each lasting its latched count.
// Assumes every length is at least 1.
module pio_phase_fsm
    import pio_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [LEN_W-1:0] s_len,
    input  logic [LEN_W-1:0] a_len,
    input  logic [LEN_W-1:0] r_len,
    output logic             ready,
    output logic             addr_valid,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic             done
);
    phase_t           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] a_q;
    logic [LEN_W-1:0] r_q;
    logic             wr_q;
    logic             last;

    assign last = (cnt == '0);

    // Advance phase and count down the current phase length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            a_q   <= '0;
            r_q   <= '0;
            wr_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (req) begin
                    phase <= PH_SETUP;
                    cnt   <= s_len - LEN_W'(1);
                    a_q   <= a_len;
                    r_q   <= r_len;
                    wr_q  <= req_write;
                end
                PH_SETUP: if (last) begin
                    phase <= PH_ACT;
                    cnt   <= a_q - LEN_W'(1);
                end else cnt <= cnt - LEN_W'(1);
                PH_ACT: if (last) begin
                    phase <= PH_REC;
                    cnt   <= r_q - LEN_W'(1);
                end else cnt <= cnt - LEN_W'(1);
                default: if (last) phase <= PH_IDLE;
                         else      cnt   <= cnt - LEN_W'(1);
            endcase
        end
    end

    // Derive the bus outputs from the current phase.
    always_comb begin
        ready      = (phase == PH_IDLE);
        addr_valid = (phase != PH_IDLE);
        rd_strobe  = (phase == PH_ACT) && !wr_q;
        wr_strobe  = (phase == PH_ACT) && wr_q;
        done       = (phase == PH_REC) && last;
    end

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_strobe, wr_strobe}));
    p_strobe_in_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> addr_valid);
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !addr_valid && !done);
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> (addr_valid && !ready && !rd_strobe && !wr_strobe));
    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done));
    p_active_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe || wr_strobe) |=> (rd_strobe || wr_strobe));
    p_strobe_to_rec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strobe || wr_strobe) |-> (addr_valid && !ready));

endmodule

// File: rtl/pio_strobe_gen.sv
// Module: top of the PIO strobe timing generator. Joins the register bank,
// the length decoder and the phase sequencer. Drives 0 and 1 own register
// sets; drives 2 and 3 share the last set. Synchronous active-low reset.
module pio_strobe_gen
    import pio_timing_pkg::*;
#(
    parameter int SETS    = 3,
    parameter int REG_W   = 8,
    parameter int DRIVE_W = 2,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         chip_rev,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               req,
    input  logic [DRIVE_W-1:0] req_drive,
    input  logic               req_write,
    input  logic               req_cmd,
    output logic               ready,
    output logic               addr_valid,
    output logic               rd_strobe,
    output logic               wr_strobe,
    output logic               done
);
    logic [SETS-1:0][REG_W-1:0] setup_regs;
    logic [SETS-1:0][REG_W-1:0] strobe_regs;
    logic [LEN_W-1:0]           s_len;
    logic [LEN_W-1:0]           a_len;
    logic [LEN_W-1:0]           r_len;

    pio_timing_regs #(.SETS(SETS), .REG_W(REG_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .setup_regs  (setup_regs),
        .strobe_regs (strobe_regs)
    );

    pio_len_decode #(.SETS(SETS), .REG_W(REG_W), .DRIVE_W(DRIVE_W)) dec_i (
        .setup_regs  (setup_regs),
        .strobe_regs (strobe_regs),
        .drive       (req_drive),
        .cmd         (req_cmd),
        .chip_rev    (chip_rev),
        .s_len       (s_len),
        .a_len       (a_len),
        .r_len       (r_len)
    );

    pio_phase_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_write   (req_write),
        .s_len       (s_len),
        .a_len       (a_len),
        .r_len       (r_len),
        .ready       (ready),
        .addr_valid  (addr_valid),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .done        (done)
    );

    p_stable_rev_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req_cmd) |-> !rd_strobe && !wr_strobe);

endmodule

// File: tb/pio_strobe_gen_tb_top.sv
module pio_strobe_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chip_rev = 2'd1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       req = 1'b0;
    logic [1:0] req_drive = '0;
    logic       req_write = 1'b0;
    logic       req_cmd = 1'b0;
    logic       ready, addr_valid, rd_strobe, wr_strobe, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pio_strobe_gen dut_i (
        .clk(clk), .rst_n(rst_n), .chip_rev(chip_rev),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_drive(req_drive),
        .req_write(req_write), .req_cmd(req_cmd), .ready(ready),
        .addr_valid(addr_valid), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_setup(input int code);
        case (code)
            0: return 4;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int exp_act(input int nib);
        if (nib == 0) return 16;
        return (nib < 2) ? 2 : nib;
    endfunction

    function automatic int exp_rec(input int nib, input int rev);
        return ((nib == 0) ? 16 : nib) + ((rev > 1) ? 1 : 0);
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int a, output int d);
        @(negedge clk);
        cfg_addr = 3'(a);
        #1 d = int'(cfg_rdata);
    endtask

    // Issue one access and measure its phases at falling edges.
    task automatic access(input int d, input bit w, input bit c,
                          input int es, input int ea, input int er, input string tag);
        int s = 0, a = 0, r = 0, dn = 0, dpos = 0, cyc = 0, bad = 0;
        bit seen = 1'b0;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_drive = 2'(d); req_write = w; req_cmd = c;
        @(negedge clk);
        req = 1'b0;
        while (addr_valid) begin
            cyc++;
            if (ready) bad++;
            if (rd_strobe || wr_strobe) begin
                a++; seen = 1'b1;
                if (w ? rd_strobe : wr_strobe) bad++;
            end else if (!seen) s++;
            else r++;
            if (done) begin dn++; dpos = cyc; end
            @(negedge clk);
        end
        check(s == es, {tag, " setup"}, s, es);
        check(a == ea, {tag, " active"}, a, ea);
        check(r == er, {tag, " recovery"}, r, er);
        check(dn == 1 && dpos == cyc, {tag, " R10 done position"}, dpos, cyc);
        check(bad == 0 && ready, {tag, " R9 R10 strobe/ready"}, bad, 0);
    endtask

    initial begin
        int rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready && !addr_valid && !rd_strobe && !wr_strobe && !done,
              "R1 idle outputs", int'(ready), 1);
        for (int i = 0; i < 6; i++) begin
            cfg_read(i, rd);
            check(rd == 0, "R1 register reset", rd, 0);
        end
        for (int d = 0; d < 4; d++)
            access(d, d[0], 1'b0, 4, 16, 16, "R1 default timing");
        chip_rev = 2'd3;
        access(2, 1'b0, 1'b0, 4, 16, 17, "R1 R6 default rev3");
        chip_rev = 2'd0;
        access(1, 1'b1, 1'b0, 4, 16, 16, "R1 R6 default rev0");

        // R7 unmapped addresses ignored
        cfg_write(6, 8'hA5);
        cfg_write(7, 8'h5A);
        cfg_read(6, rd); check(rd == 0, "R7 addr6 reads zero", rd, 0);
        cfg_read(7, rd); check(rd == 0, "R7 addr7 reads zero", rd, 0);
        for (int i = 0; i < 6; i++) begin
            cfg_read(i, rd);
            check(rd == 0, "R7 unmapped write no effect", rd, 0);
        end

        // R7 isolation and sharing
        chip_rev = 2'd1;
        cfg_write(0, 8'h40); cfg_write(1, 8'h23);
        access(0, 1'b0, 1'b0, 2, 2, 3, "R7 drive0 own set");
        access(1, 1'b0, 1'b0, 4, 16, 16, "R7 drive1 untouched");
        access(2, 1'b0, 1'b0, 4, 16, 16, "R7 drive2 untouched");
        cfg_write(4, 8'hC0); cfg_write(5, 8'h35);
        access(2, 1'b1, 1'b0, 5, 3, 5, "R7 drive2 shared");
        access(3, 1'b0, 1'b0, 5, 3, 5, "R7 drive3 shared");
        access(0, 1'b1, 1'b0, 2, 2, 3, "R7 drive0 unchanged");

        // R8 command block slowest timing
        access(0, 1'b0, 1'b1, 4, 16, 16, "R8 cmd drive0");
        chip_rev = 2'd2;
        access(3, 1'b1, 1'b1, 4, 16, 17, "R8 cmd drive3 rev2");

        // R2 R3 R4 R5 R6 sweep
        for (int rv = 1; rv <= 2; rv++) begin
            chip_rev = 2'(rv);
            for (int sc = 0; sc < 4; sc++)
                for (int an = 0; an < 16; an++)
                    for (int rn = 0; rn < 16; rn++) begin
                        int d, set, low, sv;
                        d   = (an + rn + sc) % 4;
                        set = (d < 2) ? d : 2;
                        low = (an * 5 + rn * 3 + sc) & 63;
                        sv  = (sc << 6) | low;
                        cfg_write(set * 2, sv);
                        cfg_write(set * 2 + 1, (an << 4) | rn);
                        if (an == rn) begin
                            cfg_read(set * 2, rd);
                            check(rd == sv, "R3 setup low bits kept", rd, sv);
                        end
                        access(d, 1'(rn), 1'b0, exp_setup(sc), exp_act(an),
                               exp_rec(rn, rv), "R2 R4 R5 R6 sweep");
                    end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R10: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule